// File: doc/BRIEF.md
# Supply Monitor Flag and Control Registers

This block sits between two analog supply comparators and the rest of the chip. One comparator reports that the supply has fallen under the detect (brown-out) threshold, the other that it has fallen under the earlier warning threshold. Each comparator output is synchronized into the clock domain and latched into a sticky flag. The flags raise interrupt requests and, for the detect flag, a reset request toward the system reset generator.

Software sees two 8-bit registers on a simple synchronous read/write bus. The detect register sits at offset 0 and the warning register at offset 1. Through them software picks the threshold codes that go out to the comparators, sets the interrupt and reset enables, and clears flags by writing ones to their acknowledge bits.

Two synchronous resets are supported. Power-on reset clears everything. Chip reset clears everything except the two threshold codes. A low-power-mode input suspends flag setting while it is active.

Top module: `supply_monitor_regs`

## Requirements
- R1: After power-on reset the register at offset 0 reads 0x10 (reset enable set, all else 0), offset 1 reads 0x00, and `detect_irq`, `warn_irq` and `reset_req` are 0.
- R2: A write to offset 0 stores bits [1:0] as the detect level code and bit 5 as the detect interrupt enable. A write to offset 1 stores bits [1:0] as the warning level code and bit 5 as the warning interrupt enable. The codes drive `detect_level`/`warn_level` and read back in place. Bits 3:2 of offset 0 and bits 4:2 of offset 1 read 0.
- R3: Chip reset leaves both level codes unchanged and returns all other fields to reset values. Power-on reset clears the level codes to 00.
- R4: Bit 4 of offset 0 (reset enable) takes the value of the first write to offset 0 after either reset. All later writes leave it unchanged until the next reset.
- R5: A comparator input held active sets its flag (bit 7 of its register) on the third rising edge after the input changes (two synchronizer stages, then the flag). The flag stays set after the input returns inactive.
- R6: Writing 1 to bit 6 of a register clears that register's flag. Writing 0 there leaves the flag alone. Bit 6 always reads 0.
- R7: When a flag's set condition and its acknowledge occur in the same cycle, the flag stays set.
- R8: `detect_irq` = detect flag AND detect interrupt enable, `warn_irq` = warning flag AND warning interrupt enable, and `reset_req` = detect flag AND reset enable. Each is registered, so it follows one edge after the flag.
- R9: While `low_power` is 1, neither flag becomes set, whatever the comparator inputs and register settings.
- R10: A warning input that is already active during reset sets the warning flag shortly after reset is released.
- R11: Writing 1 to bit 7 of either register does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| chip_rst | input | 1 | Synchronous active-high chip reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| below_detect | input | 1 | Asynchronous comparator: supply under detect threshold |
| below_warn | input | 1 | Asynchronous comparator: supply under warning threshold |
| low_power | input | 1 | Low-power mode active; suspends flag setting |
| detect_level | output | 2 | Detect threshold code toward the comparator |
| warn_level | output | 2 | Warning threshold code toward the comparator |
| detect_irq | output | 1 | Detect interrupt request |
| warn_irq | output | 1 | Warning interrupt request |
| reset_req | output | 1 | Reset request toward the reset generator |

## Verification
The hardest situation to reach is an acknowledge that lands in the same cycle as a set condition. The write strobe and the synchronized comparator have to line up on one edge, and the synchronizer delay makes that hard to time. The stimulus avoids the timing problem by holding the warning comparator active for the whole acknowledge write, so every cycle carries a set condition and the readback must still show the flag. Another hard case is power-on with the supply already low. The comparator input is held through a power-on reset, and the flag is then read after release.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int REG_W    = 8;
  localparam int LVL_W    = 2;
  localparam int OFS_DET  = 0;
  localparam int OFS_WARN = 1;
  // bit positions shared by both registers
  localparam int B_REN    = 4;
  localparam int B_IEN    = 5;
  localparam int B_ACK    = 6;
  localparam int B_FLAG   = 7;
  localparam logic [LVL_W-1:0] LVL_RST = '0;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[LAST];
  end
endmodule

// File: rtl/supmon_flag.sv
module supmon_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/supply_monitor_regs.sv
module supply_monitor_regs
  import supmon_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              chip_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              below_detect,
  input  logic              below_warn,
  input  logic              low_power,
  output logic [LVL_W-1:0]  detect_level,
  output logic [LVL_W-1:0]  warn_level,
  output logic              detect_irq,
  output logic              warn_irq,
  output logic              reset_req
);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFS_DET);
  localparam logic [ADDR_W-1:0] A_WARN = ADDR_W'(OFS_WARN);

  logic rst_any;
  assign rst_any = por_rst | chip_rst;

  // comparator synchronization
  logic [1:0] cmp_raw, cmp_sync;
  assign cmp_raw = {below_warn, below_detect};

  supmon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst_any),
    .d   (cmp_raw),
    .q   (cmp_sync)
  );

  // bus decode
  logic wr_det, wr_warn;
  assign wr_det  = bus_wr && !rst_any && (bus_addr == A_DET);
  assign wr_warn = bus_wr && !rst_any && (bus_addr == A_WARN);

  // power-on-only fields
  always_ff @(posedge clk) begin
    if (por_rst) begin
      detect_level <= LVL_RST;
      warn_level   <= LVL_RST;
    end else begin
      if (wr_det)  detect_level <= bus_wdata[LVL_W-1:0];
      if (wr_warn) warn_level   <= bus_wdata[LVL_W-1:0];
    end
  end

  // chip-reset fields
  logic det_ien, warn_ien, rst_en, rst_en_locked;
  always_ff @(posedge clk) begin
    if (rst_any) begin
      det_ien       <= 1'b0;
      warn_ien      <= 1'b0;
      rst_en        <= 1'b1;
      rst_en_locked <= 1'b0;
    end else begin
      if (wr_det) begin
        det_ien <= bus_wdata[B_IEN];
        if (!rst_en_locked) begin
          rst_en        <= bus_wdata[B_REN];
          rst_en_locked <= 1'b1;
        end
      end
      if (wr_warn) warn_ien <= bus_wdata[B_IEN];
    end
  end

  // sticky flags
  logic det_set, warn_set, det_ack, warn_ack, det_flag, warn_flag;
  assign det_set  = cmp_sync[0] && !low_power;
  assign warn_set = cmp_sync[1] && !low_power;
  assign det_ack  = wr_det  && bus_wdata[B_ACK];
  assign warn_ack = wr_warn && bus_wdata[B_ACK];

  supmon_flag u_det_flag (
    .clk  (clk),
    .rst  (rst_any),
    .set  (det_set),
    .clr  (det_ack),
    .flag (det_flag)
  );

  supmon_flag u_warn_flag (
    .clk  (clk),
    .rst  (rst_any),
    .set  (warn_set),
    .clr  (warn_ack),
    .flag (warn_flag)
  );

  // registered requests
  always_ff @(posedge clk) begin
    if (rst_any) begin
      detect_irq <= 1'b0;
      warn_irq   <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      detect_irq <= det_flag  & det_ien;
      warn_irq   <= warn_flag & warn_ien;
      reset_req  <= det_flag  & rst_en;
    end
  end

  // read path
  logic [REG_W-1:0] det_view, warn_view, rd_mux;
  always_comb begin
    det_view                = '0;
    det_view[LVL_W-1:0]     = detect_level;
    det_view[B_REN]         = rst_en;
    det_view[B_IEN]         = det_ien;
    det_view[B_FLAG]        = det_flag;
    warn_view               = '0;
    warn_view[LVL_W-1:0]    = warn_level;
    warn_view[B_IEN]        = warn_ien;
    warn_view[B_FLAG]       = warn_flag;
    if (bus_addr == A_DET)       rd_mux = det_view;
    else if (bus_addr == A_WARN) rd_mux = warn_view;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst_any)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[3:2], bus_wdata[B_FLAG]};

  // checks
  p_por_values_r1: assert property (@(posedge clk)
    por_rst |=> (detect_level == LVL_RST && warn_level == LVL_RST && rst_en && !det_flag));
  p_level_keep_r3: assert property (@(posedge clk) disable iff (por_rst)
    chip_rst |=> ($stable(detect_level) && $stable(warn_level)));
  p_lock_r4: assert property (@(posedge clk) disable iff (rst_any)
    rst_en_locked |=> $stable(rst_en));
  p_rise_src_r5: assert property (@(posedge clk) disable iff (rst_any)
    $rose(det_flag) |-> $past(cmp_sync[0]));
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst_any)
    $past(low_power) |-> !$rose(warn_flag) && !$rose(det_flag));
  p_req_src_r8: assert property (@(posedge clk) disable iff (rst_any)
    reset_req |-> $past(det_flag));
endmodule

// File: tb/supply_monitor_regs_test.sv
module supply_monitor_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 2;

  logic clk = 1'b0;
  logic por_rst = 1'b1, chip_rst = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic below_detect = 1'b0, below_warn = 1'b0, low_power = 1'b0;
  logic [1:0] detect_level, warn_level;
  logic detect_irq, warn_irq, reset_req;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_monitor_regs #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .por_rst(por_rst), .chip_rst(chip_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .below_detect(below_detect), .below_warn(below_warn), .low_power(low_power),
    .detect_level(detect_level), .warn_level(warn_level),
    .detect_irq(detect_irq), .warn_irq(warn_irq), .reset_req(reset_req)
  );

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got 0x%02h expected 0x%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] e, string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(logic [7:0] act, logic [7:0] e, string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", t, act, e);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    por_rst = 1'b0;
    tick(1);
    // R1
    rd(0, 8'h10, "R1 detect reg");
    rd(1, 8'h00, "R1 warn reg");
    chk({5'b0, detect_irq, warn_irq, reset_req}, 8'h00, "R1 outputs");
    // R2
    wr(0, 8'h31);
    rd(0, 8'h31, "R2 detect fields");
    chk({6'b0, detect_level}, 8'h01, "R2 detect_level");
    wr(1, 8'h1C);
    rd(1, 8'h00, "R2 reserved bits read 0");
    wr(1, 8'h23);
    rd(1, 8'h23, "R2 warn fields");
    chk({6'b0, warn_level}, 8'h03, "R2 warn_level");
    rd(2, 8'h00, "R2 unmapped offset");
    // R4 lock
    wr(0, 8'h21);
    rd(0, 8'h31, "R4 reset enable locked");
    // R11
    wr(0, 8'hB1);
    rd(0, 8'h31, "R11 flag not writable");
    // R5 / R8 latency
    below_detect = 1'b1;
    tick(3);
    chk({7'b0, detect_irq}, 8'h00, "R8 irq not yet");
    tick(1);
    chk({6'b0, detect_irq, reset_req}, 8'h03, "R8 detect irq and reset req");
    below_detect = 1'b0;
    tick(4);
    rd(0, 8'hB1, "R5 flag sticky");
    wr(0, 8'h31);
    rd(0, 8'hB1, "R6 ack zero keeps flag");
    wr(0, 8'h71);
    rd(0, 8'h31, "R6 ack clears, reads 0");
    chk({6'b0, detect_irq, reset_req}, 8'h00, "R6 requests drop");
    // R7 set wins
    below_warn = 1'b1;
    tick(5);
    chk({7'b0, warn_irq}, 8'h01, "R8 warn irq");
    wr(1, 8'h63);
    rd(1, 8'hA3, "R7 set beats ack");
    below_warn = 1'b0;
    tick(4);
    wr(1, 8'h63);
    rd(1, 8'h23, "R6 warn ack clears");
    // R9
    low_power = 1'b1;
    below_detect = 1'b1;
    below_warn = 1'b1;
    tick(6);
    rd(0, 8'h31, "R9 detect suppressed");
    rd(1, 8'h23, "R9 warn suppressed");
    chk({5'b0, detect_irq, warn_irq, reset_req}, 8'h00, "R9 no requests");
    below_detect = 1'b0;
    below_warn = 1'b0;
    tick(4);
    low_power = 1'b0;
    tick(2);
    // R3 chip reset
    chip_rst = 1'b1;
    tick(2);
    chip_rst = 1'b0;
    tick(1);
    rd(0, 8'h11, "R3 chip reset keeps detect level");
    rd(1, 8'h03, "R3 chip reset keeps warn level");
    chk({4'b0, detect_level, warn_level}, 8'h07, "R3 level outputs");
    // R4 rearmed
    wr(0, 8'h01);
    rd(0, 8'h01, "R4 first write after reset");
    wr(0, 8'h11);
    rd(0, 8'h01, "R4 later write ignored");
    below_detect = 1'b1;
    tick(5);
    chk({7'b0, reset_req}, 8'h00, "R4 no reset req when disabled");
    rd(0, 8'h81, "R5 flag with requests off");
    below_detect = 1'b0;
    tick(4);
    wr(0, 8'h41);
    rd(0, 8'h01, "R6 detect ack");
    // R10 and R3 power-on
    below_warn = 1'b1;
    por_rst = 1'b1;
    tick(3);
    por_rst = 1'b0;
    tick(5);
    rd(1, 8'h80, "R10 warn flag after power-on");
    rd(0, 8'h10, "R3 power-on clears detect level");
    chk({4'b0, detect_level, warn_level}, 8'h00, "R3 levels cleared");
    below_warn = 1'b0;
    tick(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule